// File: doc/BRIEF.md
# Timed Receive Stream Command Engine

This block sits between a host register bus and a receive sample path. The host describes a capture with three register writes: a command word, a seconds value and a ticks value. The ticks write commits all three as one entry into a small command queue. The engine takes entries from the queue one at a time. It either opens the sample gate at once, or waits until a free-running 64-bit time input (seconds in the upper half, ticks in the lower half) reaches the commanded time. The gate stays open for the commanded number of samples, one per clock.

Flags in the command word select what happens when the count runs out. With no flags the engine stops and marks the last sample as the end of a burst. With chain set it moves straight to the next queued command without a gap. With reload set it repeats the current command for as long as the queue is empty, which gives a continuous stream. A stop command has no flags and a count of one. If a chained command runs out with nothing queued, the engine raises an overrun and stays halted until the host clears it. A timed command whose moment has already passed is dropped and reported as late. A command written while the queue is full is discarded and sets a sticky error.

Top module: `rxcmd_engine`

## Requirements
- R1: Register addresses are 0 = command word, 1 = seconds, 2 = ticks and 3 = clear; other addresses are ignored. In the command word, bit 31 is start-now, bit 30 is chain, bit 29 is reload, and bits 28..0 hold the sample count (at most 0x1FFFFFFF).
- R2: Writing the command word or the seconds register queues nothing. A write to the ticks register pushes the entry {command word, seconds, ticks}. With start-now set and the engine idle, samp_en first goes high in the second cycle after the cycle in which the ticks write is presented.
- R3: A started command produces exactly its count of samples on consecutive cycles. A count of 0 behaves as a count of 1.
- R4: With start-now clear, samp_en rises in the cycle after the first clock edge at which time_now >= {seconds, ticks}.
- R5: If time_now is already greater than the command time when a timed command is taken from the queue, the command is dropped and produces no samples. late_err pulses high for one cycle, and samp_en is low in that cycle.
- R6: When a command with chain and reload both clear runs out, burst_end is high together with its last sample, and samp_en is low in the next cycle.
- R7: When a command with chain set runs out and an immediate command is queued, the queued command's samples follow with no idle cycle and without burst_end at the junction.
- R8: When a command with chain set and reload clear runs out and the queue is empty, overrun goes high and no samples are produced. Both conditions hold until a clear write, even if new commands are queued in the meantime.
- R9: With reload set, the command repeats its count without a gap while the queue is empty. When an entry is waiting at the end of a count, the engine takes that entry instead.
- R10: The queue holds DEPTH entries (default 4) in addition to the command being executed. A ticks write while the queue is full is discarded and sets queue_err, which stays high.
- R11: Any write to the clear register clears overrun and queue_err. An engine halted by overrun then resumes with the next queued command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | 32 | Register write data |
| time_now | input | 64 | Running time, {seconds, ticks} |
| samp_en | output | 1 | Sample gate, one sample per high cycle |
| burst_end | output | 1 | Marks the last sample of a finished burst |
| late_err | output | 1 | One-cycle pulse when a late command is dropped |
| overrun | output | 1 | Chained command ran out with the queue empty |
| queue_err | output | 1 | Sticky: a command was lost to a full queue |

## Verification
The bench sweeps counts from 0 to 8. A design that gated the count off by one, or let a zero count run until the counter wraps, would show up as a wrong sample total or a misplaced burst end. It also sweeps start times from exactly the take-up moment outward across a carry from ticks into seconds: a compare that ignored the seconds half, or that treated equality as late, would start at the wrong time or drop the command. The chain, reload and overrun cases look for gaps at the junctions, for a reload that never hands over to a queued stop, and for an overrun that lets queued work through before the clear. The full-queue case counts the total samples afterwards, so a fifth entry that overwrote a slot would add fifty samples.

// File: rtl/rxcmd_pkg.sv
package rxcmd_pkg;

    localparam int CNT_W   = 29;
    localparam int TIME_W  = 64;
    localparam int WORD_W  = 32;

    localparam int BIT_NOW    = 31;
    localparam int BIT_CHAIN  = 30;
    localparam int BIT_RELOAD = 29;

    localparam int REG_CMD   = 0;
    localparam int REG_SECS  = 1;
    localparam int REG_TICKS = 2;
    localparam int REG_CLEAR = 3;

    typedef struct packed {
        logic              now;
        logic              chain;
        logic              reload;
        logic [CNT_W-1:0]  count;
        logic [TIME_W-1:0] when;
    } rx_cmd_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_RUN,
        ST_OVR
    } seq_st_e;

    function automatic logic [CNT_W-1:0] load_count(input logic [CNT_W-1:0] c);
        return (c == '0) ? CNT_W'(1) : c;
    endfunction

endpackage

// File: rtl/rxcmd_regs.sv
module rxcmd_regs
    import rxcmd_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              fifo_full,
    output logic              push,
    output rx_cmd_t           push_cmd,
    output logic              clear,
    output logic              queue_err
);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [WORD_W-1:0] secs;
        logic              err;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d   = r_q;
        push  = wr_en && (wr_addr == ADDR_W'(REG_TICKS));
        clear = wr_en && (wr_addr == ADDR_W'(REG_CLEAR));

        if (wr_en && (wr_addr == ADDR_W'(REG_CMD)))  r_d.word = wr_data;
        if (wr_en && (wr_addr == ADDR_W'(REG_SECS))) r_d.secs = wr_data;

        if (clear)                  r_d.err = 1'b0;
        else if (push && fifo_full) r_d.err = 1'b1;

        push_cmd.now    = r_q.word[BIT_NOW];
        push_cmd.chain  = r_q.word[BIT_CHAIN];
        push_cmd.reload = r_q.word[BIT_RELOAD];
        push_cmd.count  = r_q.word[CNT_W-1:0];
        push_cmd.when   = {r_q.secs, wr_data};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign queue_err = r_q.err;

endmodule

// File: rtl/rxcmd_fifo.sv
module rxcmd_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 96
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] rd;
        logic [AW-1:0] wr;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t p_d, p_q;
    logic [W-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        p_d     = p_q;
        empty   = (p_q.cnt == '0);
        full    = (p_q.cnt == CW'(DEPTH));
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (do_push) p_d.wr = bump(p_q.wr);
        if (do_pop)  p_d.rd = bump(p_q.rd);
        if (do_push && !do_pop)      p_d.cnt = p_q.cnt + CW'(1);
        else if (do_pop && !do_push) p_d.cnt = p_q.cnt - CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[p_q.wr] <= din;
    end

    assign dout = mem_q[p_q.rd];

endmodule

// File: rtl/rxcmd_seq.sv
module rxcmd_seq
    import rxcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  rx_cmd_t           head,
    input  logic              empty,
    input  logic [TIME_W-1:0] time_now,
    input  logic              clear,
    output logic              pop,
    output logic              samp_en,
    output logic              burst_end,
    output logic              late_err,
    output logic              overrun
);

    typedef struct packed {
        seq_st_e          st;
        rx_cmd_t          cur;
        logic [CNT_W-1:0] cnt;
        logic             late;
    } seq_t;

    seq_t s_d, s_q;
    logic launch;

    always_comb begin
        s_d      = s_q;
        s_d.late = 1'b0;
        pop      = 1'b0;
        launch   = 1'b0;

        case (s_q.st)
            ST_IDLE: launch = !empty;
            ST_WAIT: begin
                if (time_now >= s_q.cur.when) begin
                    s_d.st  = ST_RUN;
                    s_d.cnt = load_count(s_q.cur.count);
                end
            end
            ST_RUN: begin
                if (s_q.cnt == CNT_W'(1)) begin
                    if (s_q.cur.reload && empty)
                        s_d.cnt = load_count(s_q.cur.count);
                    else if ((s_q.cur.reload || s_q.cur.chain) && !empty)
                        launch = 1'b1;
                    else if (s_q.cur.chain)
                        s_d.st = ST_OVR;
                    else
                        s_d.st = ST_IDLE;
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
            ST_OVR: if (clear) s_d.st = ST_IDLE;
            default: s_d.st = ST_IDLE;
        endcase

        if (launch) begin
            pop     = 1'b1;
            s_d.cur = head;
            s_d.cnt = load_count(head.count);
            if (head.now || (time_now == head.when)) begin
                s_d.st = ST_RUN;
            end else if (time_now > head.when) begin
                s_d.st   = ST_IDLE;
                s_d.late = 1'b1;
            end else begin
                s_d.st = ST_WAIT;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, cur: '0, cnt: '0, late: 1'b0};
        else        s_q <= s_d;
    end

    assign samp_en   = (s_q.st == ST_RUN);
    assign burst_end = samp_en && (s_q.cnt == CNT_W'(1))
                       && !s_q.cur.chain && !s_q.cur.reload;
    assign overrun   = (s_q.st == ST_OVR);
    assign late_err  = s_q.late;

endmodule

// File: rtl/rxcmd_engine.sv
module rxcmd_engine
    import rxcmd_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [63:0]       time_now,
    output logic              samp_en,
    output logic              burst_end,
    output logic              late_err,
    output logic              overrun,
    output logic              queue_err
);

    localparam int ENTRY_W = $bits(rx_cmd_t);

    logic    push, pop, clear, q_empty, q_full;
    rx_cmd_t push_cmd, head;

    rxcmd_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .fifo_full (q_full),
        .push      (push),
        .push_cmd  (push_cmd),
        .clear     (clear),
        .queue_err (queue_err)
    );

    rxcmd_fifo #(.DEPTH(DEPTH), .W(ENTRY_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   (push_cmd),
        .pop   (pop),
        .dout  (head),
        .empty (q_empty),
        .full  (q_full)
    );

    rxcmd_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .head      (head),
        .empty     (q_empty),
        .time_now  (time_now),
        .clear     (clear),
        .pop       (pop),
        .samp_en   (samp_en),
        .burst_end (burst_end),
        .late_err  (late_err),
        .overrun   (overrun)
    );

endmodule

// File: rtl/rxcmd_engine_chk.sv
module rxcmd_engine_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              samp_en,
    input logic              burst_end,
    input logic              late_err,
    input logic              overrun,
    input logic              queue_err
);

    logic clr_wr;
    assign clr_wr = wr_en && (wr_addr == ADDR_W'(3));

    // R6
    end_with_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burst_end |-> samp_en);

    // R6
    quiet_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burst_end |=> !samp_en);

    // R5
    late_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        late_err |-> !samp_en);

    // R8
    overrun_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> !samp_en);

    // R8
    overrun_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !clr_wr) |=> overrun);

    // R11
    overrun_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> !overrun);

    // R10
    qerr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (queue_err && !clr_wr) |=> queue_err);

    // R11
    qerr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> !queue_err);

endmodule

bind rxcmd_engine rxcmd_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .samp_en   (samp_en),
    .burst_end (burst_end),
    .late_err  (late_err),
    .overrun   (overrun),
    .queue_err (queue_err)
);

// File: tb/rxcmd_engine_test.sv
`timescale 1ns/1ps
module rxcmd_engine_test;

    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [63:0]   tnow;
    logic samp_en, burst_end, late_err, overrun, queue_err;

    int  n_chk = 0, n_fail = 0;
    bit  finished = 1'b0;
    int  tot_s = 0, tot_e = 0, tot_rise = 0, tot_late = 0, run = 0, eob_run = 0;
    logic [63:0] first_t = '0;
    logic prev = 1'b0;

    rxcmd_engine #(.ADDR_W(AW), .DEPTH(4)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .time_now(tnow), .samp_en(samp_en),
        .burst_end(burst_end), .late_err(late_err), .overrun(overrun),
        .queue_err(queue_err)
    );

    always #4 clk = ~clk;

    // ticks start close to their wrap so timed starts cross into seconds
    always @(posedge clk) begin
        if (!rst_n) tnow <= {32'd5, 32'hFFFF_FFC0};
        else        tnow <= tnow + 64'd1;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (samp_en) begin
                tot_s = tot_s + 1;
                if (!prev) begin
                    tot_rise = tot_rise + 1;
                    run = 0;
                    first_t = tnow;
                end
                run = run + 1;
                if (burst_end) begin
                    tot_e = tot_e + 1;
                    eob_run = run;
                end
            end
            if (late_err) tot_late = tot_late + 1;
            prev = samp_en;
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int k);
        repeat (k) @(negedge clk);
        #1;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        wr_en = 1'b1;
        wr_addr = AW'(a);
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    task automatic push(input bit now, input bit chain, input bit reload,
                        input int cnt, input logic [63:0] t);
        wr(0, {now, chain, reload, 29'(cnt)});
        wr(1, t[63:32]);
        wr(2, t[31:0]);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        int s0, e0, r0, l0, exp_n;
        logic [63:0] t;
        @(negedge clk);
        step(4);
        rst_n = 1'b1;
        step(1);
        chk("R1 reset samp_en", samp_en, 0);
        chk("R1 reset overrun", overrun, 0);
        chk("R1 reset queue_err", queue_err, 0);
        chk("R1 reset burst_end", burst_end, 0);

        // R4 timed starts, D = 3 meets the take-up edge exactly
        for (int d = 3; d <= 12; d++) begin
            s0 = tot_s; l0 = tot_late;
            t = tnow + 64'(d);
            push(1'b0, 1'b0, 1'b0, 3, t);
            step(d + 10);
            chk("R4 start time", first_t, t + 64'd1);
            chk("R4 timed count", tot_s - s0, 3);
            chk("R4 not late", tot_late - l0, 0);
        end

        // R5 a time two cycles ahead is already past at take-up
        s0 = tot_s; l0 = tot_late;
        push(1'b0, 1'b0, 1'b0, 4, tnow + 64'd2);
        step(8);
        chk("R5 late pulse", tot_late - l0, 1);
        chk("R5 late no samples", tot_s - s0, 0);

        // R2 staging writes alone queue nothing
        s0 = tot_s;
        wr(0, 32'h8000_0005);
        wr(1, 32'd0);
        step(6);
        chk("R2 no commit without ticks", tot_s - s0, 0);

        // R3 R6 immediate counts, zero acts as one
        for (int n = 0; n <= 8; n++) begin
            s0 = tot_s; e0 = tot_e; r0 = tot_rise;
            exp_n = (n == 0) ? 1 : n;
            push(1'b1, 1'b0, 1'b0, n, 64'd0);
            chk("R2 latency low", samp_en, 0);
            step(1);
            chk("R2 latency high", samp_en, 1);
            step(n + 4);
            chk("R3 count", tot_s - s0, exp_n);
            chk("R3 contiguous", tot_rise - r0, 1);
            chk("R6 one burst end", tot_e - e0, 1);
            chk("R6 end on last", eob_run, exp_n);
        end

        // R7 chained into a queued finite burst
        s0 = tot_s; e0 = tot_e; r0 = tot_rise;
        push(1'b1, 1'b1, 1'b0, 12, 64'd0);
        push(1'b1, 1'b0, 1'b0, 5, 64'd0);
        step(20);
        chk("R7 chained total", tot_s - s0, 17);
        chk("R7 no gap", tot_rise - r0, 1);
        chk("R7 single end", tot_e - e0, 1);
        chk("R7 end position", eob_run, 17);

        // R8 R11 chain with empty queue halts until clear
        s0 = tot_s; e0 = tot_e;
        push(1'b1, 1'b1, 1'b0, 6, 64'd0);
        step(12);
        chk("R8 samples before halt", tot_s - s0, 6);
        chk("R8 overrun set", overrun, 1);
        chk("R8 no burst end", tot_e - e0, 0);
        push(1'b1, 1'b0, 1'b0, 2, 64'd0);
        step(8);
        chk("R8 held while halted", tot_s - s0, 6);
        chk("R8 overrun held", overrun, 1);
        wr(3, 32'd0);
        step(8);
        chk("R11 overrun cleared", overrun, 0);
        chk("R11 resumes queued", tot_s - s0, 8);
        chk("R11 resumed burst end", tot_e - e0, 1);

        // R9 continuous stream then a stop command
        e0 = tot_e; r0 = tot_rise;
        push(1'b1, 1'b1, 1'b1, 4, 64'd0);
        step(30);
        chk("R9 still streaming", samp_en, 1);
        chk("R9 no end while reloading", tot_e - e0, 0);
        push(1'b1, 1'b0, 1'b0, 1, 64'd0);
        step(12);
        chk("R9 stopped", samp_en, 0);
        chk("R9 stop ends burst", tot_e - e0, 1);
        chk("R9 no gap at handover", tot_rise - r0, 1);
        chk("R9 whole repeats plus one", (eob_run - 1) % 4, 0);

        // R10 full queue behind a waiting command
        s0 = tot_s; e0 = tot_e; r0 = tot_rise;
        push(1'b0, 1'b0, 1'b0, 3, tnow + 64'd300);
        for (int k = 0; k < 4; k++) push(1'b1, 1'b0, 1'b0, 2, 64'd0);
        chk("R10 four fit", queue_err, 0);
        push(1'b1, 1'b0, 1'b0, 50, 64'd0);
        chk("R10 overflow flagged", queue_err, 1);
        step(360);
        chk("R10 dropped entry absent", tot_s - s0, 11);
        chk("R10 bursts", tot_e - e0, 5);
        chk("R10 sticky", queue_err, 1);
        wr(3, 32'd1);
        step(1);
        chk("R11 queue_err cleared", queue_err, 0);

        finished = 1'b1;
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            summary();
        end
    end

endmodule